// File: doc/BRIEF.md
# Pointer-Addressed Instruction Store

This block holds a short program of byte-wide instructions. A host fills and inspects it through two registers. The first is an address pointer that the host can load and read back. The second is a data window onto the location the pointer selects. Every time the host touches the data window, by a read or a write strobe, the pointer moves to the next location. The host can therefore stream a whole program after it loads the start address once.

A second port is read-only and indexed. A sequencer uses it to fetch an instruction combinationally at the same time as host traffic, without moving the host pointer. The store is cleared at reset. A host write lands at the clock edge, so a fetch of the location being written in that same cycle still returns the earlier byte.

Top module: `ibuf_port`

## Requirements
- R1: While reset is asserted and after its release, the pointer reads 0 and every location holds 0x00.
- R2: A cycle with `host_data_wr` high stores `host_data_wdata` at the location the pointer held in that cycle.
- R3: `host_data_rdata` shows, combinationally, the byte stored at the current pointer value.
- R4: After a clock edge with `host_data_wr` or `host_data_rd` high and `host_ptr_wr` low, the pointer has grown by one.
- R5: An advance from location DEPTH-1 (63 by default) takes the pointer to 0.
- R6: After a clock edge with `host_ptr_wr` high, the pointer equals `host_ptr_wdata`. A direct load overrides the advance from a data access in the same cycle, but that access still uses the old pointer.
- R7: A read strobe and a write strobe in the same cycle advance the pointer by exactly one. The write is stored, and the read shows the byte from before the write.
- R8: `seq_instr` shows the byte at `seq_idx` for any index. A cycle with no host strobe leaves the pointer unchanged, whatever the index is.
- R9: When the host writes the location that `seq_idx` selects, `seq_instr` shows the old byte in that cycle and the new byte from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ptr_wr | input | 1 | Load the pointer from `host_ptr_wdata` |
| host_ptr_wdata | input | PTR_W (6) | New pointer value |
| host_ptr_rdata | output | PTR_W (6) | Current pointer |
| host_data_wr | input | 1 | Write strobe for the data window |
| host_data_wdata | input | DATA_W (8) | Byte to store |
| host_data_rd | input | 1 | Read strobe for the data window (advances the pointer) |
| host_data_rdata | output | DATA_W (8) | Byte at the pointer |
| seq_idx | input | PTR_W (6) | Sequencer fetch index |
| seq_instr | output | DATA_W (8) | Byte at `seq_idx` |

## Verification
The assertions assume that the strobes are clean single-cycle levels sampled at the rising edge. They also assume that `host_ptr_wdata` is below DEPTH whenever `host_ptr_wr` is high, and the default power-of-two depth makes every 6-bit value legal. The stimulus changes inputs only at falling edges and keeps the strobes low during reset. Its pointer loads stay inside 0..63, so every pointer value the checks rely on is reachable.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
  localparam int DEF_DEPTH  = 64;
  localparam int DEF_DATA_W = 8;

  // Next pointer value with wrap at the end of the store.
  function automatic int ptr_advance(input int depth, input int cur);
    return (cur >= depth - 1) ? 0 : cur + 1;
  endfunction

  // Kind of host data access seen in one cycle.
  typedef enum logic [1:0] {
    ACC_NONE  = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_BOTH  = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/ibuf_ptr.sv
module ibuf_ptr #(
  parameter int DEPTH = ibuf_pkg::DEF_DEPTH,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step_en,
  output logic [PTR_W-1:0] ptr_q,
  output logic             wrap_evt
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_next;

  assign ptr_next = PTR_W'(ibuf_pkg::ptr_advance(DEPTH, int'(ptr_q)));
  assign wrap_evt = step_en && !load_en && (ptr_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (load_en) ptr_q <= load_val;
    else if (step_en) ptr_q <= ptr_next;
  end

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> ptr_q == $past(load_val)); // R6
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ptr_q == '0); // R5
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !step_en) |=> $stable(ptr_q)); // R8
endmodule

// File: rtl/ibuf_mem.sv
module ibuf_mem #(
  parameter int DEPTH  = ibuf_pkg::DEF_DEPTH,
  parameter int DATA_W = ibuf_pkg::DEF_DATA_W,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [PTR_W-1:0]  rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else if (wr_en) begin
      store[wr_addr] <= wr_data;
    end
  end

  assign rd_a_data = store[rd_a_addr];
  assign rd_b_data = store[rd_b_addr];

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> store[$past(wr_addr)] == $past(wr_data)); // R2
endmodule

// File: rtl/ibuf_port.sv
module ibuf_port #(
  parameter int DEPTH  = ibuf_pkg::DEF_DEPTH,
  parameter int DATA_W = ibuf_pkg::DEF_DATA_W,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_ptr_wr,
  input  logic [PTR_W-1:0]  host_ptr_wdata,
  output logic [PTR_W-1:0]  host_ptr_rdata,
  input  logic              host_data_wr,
  input  logic [DATA_W-1:0] host_data_wdata,
  input  logic              host_data_rd,
  output logic [DATA_W-1:0] host_data_rdata,
  input  logic [PTR_W-1:0]  seq_idx,
  output logic [DATA_W-1:0] seq_instr
);
  ibuf_pkg::acc_kind_e acc_kind;
  logic                access_evt;
  logic                step_evt;
  logic                wrap_evt;
  logic [PTR_W-1:0]    ptr_q;

  assign acc_kind   = ibuf_pkg::acc_kind_e'({host_data_wr, host_data_rd});
  assign access_evt = (acc_kind != ibuf_pkg::ACC_NONE);
  assign step_evt   = access_evt && !host_ptr_wr;

  ibuf_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (host_ptr_wr),
    .load_val (host_ptr_wdata),
    .step_en  (access_evt),
    .ptr_q    (ptr_q),
    .wrap_evt (wrap_evt)
  );

  ibuf_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (host_data_wr),
    .wr_addr   (ptr_q),
    .wr_data   (host_data_wdata),
    .rd_a_addr (ptr_q),
    .rd_a_data (host_data_rdata),
    .rd_b_addr (seq_idx),
    .rd_b_data (seq_instr)
  );

  assign host_ptr_rdata = ptr_q;

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !wrap_evt) |=> host_ptr_rdata == $past(host_ptr_rdata) + 1'b1); // R4
  AST_BOTH_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == ibuf_pkg::ACC_BOTH && step_evt && !wrap_evt)
      |=> host_ptr_rdata == $past(host_ptr_rdata) + 1'b1); // R7
  AST_SEQ_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_data_wr && seq_idx == host_ptr_rdata && $stable(seq_idx))
      |=> seq_instr == $past(host_data_wdata)); // R9
endmodule

// File: tb/tb_ibuf_port.sv
module tb_ibuf_port;
  localparam int DEPTH = 64;
  localparam int DW = 8;
  localparam int PW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_ptr_wr = 1'b0;
  logic [PW-1:0] host_ptr_wdata = '0;
  logic [PW-1:0] host_ptr_rdata;
  logic          host_data_wr = 1'b0;
  logic [DW-1:0] host_data_wdata = '0;
  logic          host_data_rd = 1'b0;
  logic [DW-1:0] host_data_rdata;
  logic [PW-1:0] seq_idx = '0;
  logic [DW-1:0] seq_instr;

  always #5 clk = ~clk;

  ibuf_port dut (.*);

  typedef struct {
    string    req;
    int       sel;
    int       exp;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int mdl [DEPTH];
  int mptr = 0;

  // Drive one cycle at the falling edge, queue the expected outputs for this cycle,
  // then update the model as the clock edge will.
  task automatic op(input string req, input bit pw, input int pv, input bit dw,
                    input int dv, input bit dr, input int si);
    @(negedge clk);
    host_ptr_wr = pw; host_ptr_wdata = PW'(pv);
    host_data_wr = dw; host_data_wdata = DW'(dv);
    host_data_rd = dr; seq_idx = PW'(si);
    q.push_back('{req, 0, mptr});
    q.push_back('{req, 1, mdl[mptr]});
    q.push_back('{req, 2, mdl[si]});
    if (dw) mdl[mptr] = dv;
    if (pw) mptr = pv;
    else if (dw || dr) mptr = (mptr + 1) % DEPTH;
  endtask

  task automatic idle(input string req, input int si);
    op(req, 0, 0, 0, 0, 0, si);
  endtask

  // Monitor: pops queued expectations once the combinational outputs have settled.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        case (it.sel)
          0: act = int'(host_ptr_rdata);
          1: act = int'(host_data_rdata);
          default: act = int'(seq_instr);
        endcase
        checks++;
        if (act != it.exp) begin
          fails++;
          $display("FAIL %s: output %0d actual 0x%0h expected 0x%0h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1", 37);
    idle("R1", 63);
    // R6: load pointer near the end, then stream writes across the wrap (R2, R4, R5)
    op("R6", 1, 60, 0, 0, 0, 0);
    for (int k = 0; k < 8; k++) op("R2_R4_R5", 0, 0, 1, 'hA0 + k, 0, 60 + k);
    idle("R5", 62);
    // R3: read back by streaming reads from location 60
    op("R6", 1, 60, 0, 0, 0, 0);
    for (int k = 0; k < 8; k++) op("R3_R4", 0, 0, 0, 0, 1, k);
    idle("R3", 3);
    // R7: read and write together at pointer 4
    op("R6", 1, 4, 0, 0, 0, 4);
    op("R7", 0, 0, 1, 'h5C, 1, 4);
    idle("R7", 4);
    // R9: write the location the sequencer is fetching
    op("R6", 1, 9, 0, 0, 0, 9);
    op("R9", 0, 0, 1, 'h3E, 0, 9);
    idle("R9", 9);
    // R6 priority: a load and a write in one cycle
    op("R6", 1, 20, 1, 'h77, 0, 10);
    idle("R6", 10);
    op("R6", 1, 10, 0, 0, 0, 0);
    idle("R6", 10);
    // R8: sequencer sweep without host strobes
    for (int k = 0; k < DEPTH; k += 7) idle("R8", k);
    // R5 by read at 63
    op("R6", 1, 63, 0, 0, 0, 0);
    op("R5", 0, 0, 0, 0, 1, 63);
    idle("R5", 0);
    @(negedge clk);
    #4;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule